// File: doc/BRIEF.md
# LIN Frame Timeout Monitor

This block watches the frame-level progress of one LIN node, acting as master or slave, and raises a sticky timeout flag when a frame stalls. It does not sample bits or compute checksums. It takes event strobes from the protocol engine and derives deadlines from two timing ticks: one pulse per bit time and one per millisecond. The strobes are: break/sync seen, identifier received, data byte received, frame complete, wakeup sent, and application acknowledge or stop.

Four independent watchers feed one timeout flag:
- a whole-frame deadline, counted in bit times from the break;
- a response-silence deadline, for use while data is expected;
- a slave-only deadline for the application handshake after the identifier;
- a slave-only wakeup-to-sync watchdog, counted in milliseconds.

The block also latches error strobes it is handed (sync, parity, checksum) and detects bit errors by comparing the driven and monitored bus values in a bit slot. All flags appear in an 8-bit status word that software clears with a single strobe.

Top module: `lin_tmo_mon`

## Requirements
- R1: After reset `err_stat` is 0 and `tmo_flag` is 0. `err_stat` bits 7..5 always read 0. The field positions are: bit 4 sync error, bit 3 parity error, bit 2 timeout, bit 1 checksum error, bit 0 bit error.
- R2: A timeout is flagged when FRAME_MAX_BITS bit ticks have been counted since the last `brk_sync_seen` without `frame_done`. The flag is visible in the cycle after the cycle that carries the FRAME_MAX_BITS-th tick.
- R3: `frame_done` stops every frame deadline. No bit ticks after it can raise a timeout until the next break.
- R4: After `id_rcvd` with `expect_rx` high, RESP_MAX_BITS bit ticks with no `byte_rcvd` raise a timeout, in either mode. Each received byte restarts the silence count. With `expect_rx` low at the identifier, no silence deadline is armed.
- R5: In slave mode, if the first `byte_rcvd` after `id_rcvd` arrives before any `app_ack` or `app_stop`, a timeout is flagged. An acknowledge or stop in the same cycle as that byte is in time. In master mode this deadline is never armed.
- R6: In slave mode, WAKE_MS millisecond ticks after `wake_sent` with no `brk_sync_seen` raise a timeout. A break before then cancels the watchdog. In master mode `wake_sent` arms nothing.
- R7: `sync_err_in` sets bit 4 and `parity_err_in` sets bit 3 only while `is_master` is 0. In master mode they have no effect.
- R8: A `bit_slot` cycle with `bit_drv` different from `bit_mon` sets bit 0. `chk_err_in` sets bit 1 in either mode.
- R9: Every status bit is sticky until `clr_err`. A set in the same cycle as the clear wins. `tmo_flag` always equals status bit 2.
- R10: A new `brk_sync_seen` restarts the frame deadline from zero, even while a frame is still in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| is_master | input | 1 | 1 = node acts as master, 0 = slave |
| expect_rx | input | 1 | Node expects response data in this frame (sampled at `id_rcvd`) |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| brk_sync_seen | input | 1 | Break and sync field detected |
| id_rcvd | input | 1 | Identifier byte received |
| byte_rcvd | input | 1 | Data or checksum byte received |
| frame_done | input | 1 | Frame completed |
| wake_sent | input | 1 | Node transmitted a wakeup signal |
| app_ack | input | 1 | Application acknowledged the identifier |
| app_stop | input | 1 | Application chose to stop the frame |
| sync_err_in | input | 1 | Sync field tolerance violation strobe |
| parity_err_in | input | 1 | Identifier parity error strobe |
| chk_err_in | input | 1 | Checksum error strobe |
| bit_slot | input | 1 | Bit comparison strobe |
| bit_drv | input | 1 | Value driven onto the bus in this slot |
| bit_mon | input | 1 | Value read back from the bus in this slot |
| clr_err | input | 1 | Clear all status bits |
| tmo_flag | output | 1 | Sticky timeout flag |
| err_stat | output | 8 | Error status word |

## Verification
The bench builds the block with FRAME_MAX_BITS = 40, RESP_MAX_BITS = 8 and WAKE_MS = 150. The short frame and silence limits let each deadline be probed exactly one tick before and at its limit within a few dozen cycles. The frame limit is kept well above the silence limit, so the two deadlines can be told apart. Keeping the full 150-tick wakeup window exercises the real counter width, because the bench pulses `ms_tick` every cycle.

// File: rtl/lin_tmo_pkg.sv
package lin_tmo_pkg;

  localparam int unsigned STAT_W = 8;

  // Status flags; packed order gives bit 4 down to bit 0 of the status word
  typedef struct packed {
    logic syn;
    logic par;
    logic tmo;
    logic chk;
    logic bit_e;
  } err_flags_t;

  localparam int unsigned FLAG_W = $bits(err_flags_t);

endpackage

// File: rtl/lin_frame_timer.sv
module lin_frame_timer #(
  parameter int unsigned FRAME_MAX_BITS = 176,
  parameter int unsigned RESP_MAX_BITS  = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic brk_sync_seen,
  input  logic id_rcvd,
  input  logic byte_rcvd,
  input  logic frame_done,
  input  logic expect_rx,
  output logic frm_tmo,
  output logic rsp_tmo
);

  localparam int unsigned FW = $clog2(FRAME_MAX_BITS + 1);
  localparam int unsigned SW = $clog2(RESP_MAX_BITS + 1);
  localparam logic [FW-1:0] FRM_LAST = FW'(FRAME_MAX_BITS - 1);
  localparam logic [SW-1:0] SIL_LAST = SW'(RESP_MAX_BITS - 1);

  logic          frm_act_q, frm_act_d;
  logic [FW-1:0] frm_cnt_q, frm_cnt_d;
  logic          rsp_act_q, rsp_act_d;
  logic [SW-1:0] sil_cnt_q, sil_cnt_d;

  // deadline hits for this cycle
  always_comb begin
    frm_tmo = frm_act_q && bit_tick && (frm_cnt_q == FRM_LAST) &&
              !brk_sync_seen && !frame_done;
    rsp_tmo = rsp_act_q && bit_tick && (sil_cnt_q == SIL_LAST) &&
              !brk_sync_seen && !frame_done && !byte_rcvd && !id_rcvd;
  end

  // whole-frame counter next state
  always_comb begin
    frm_act_d = frm_act_q;
    frm_cnt_d = frm_cnt_q;
    if (brk_sync_seen) begin
      frm_act_d = 1'b1;
      frm_cnt_d = '0;
    end else if (frame_done || frm_tmo) begin
      frm_act_d = 1'b0;
    end else if (frm_act_q && bit_tick) begin
      frm_cnt_d = frm_cnt_q + 1'b1;
    end
  end

  // response silence counter next state
  always_comb begin
    rsp_act_d = rsp_act_q;
    sil_cnt_d = sil_cnt_q;
    if (brk_sync_seen || frame_done || frm_tmo || rsp_tmo) begin
      rsp_act_d = 1'b0;
      sil_cnt_d = '0;
    end else if (id_rcvd) begin
      rsp_act_d = expect_rx;
      sil_cnt_d = '0;
    end else if (byte_rcvd) begin
      sil_cnt_d = '0;
    end else if (rsp_act_q && bit_tick) begin
      sil_cnt_d = sil_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_act_q <= 1'b0;
      frm_cnt_q <= '0;
      rsp_act_q <= 1'b0;
      sil_cnt_q <= '0;
    end else begin
      frm_act_q <= frm_act_d;
      frm_cnt_q <= frm_cnt_d;
      rsp_act_q <= rsp_act_d;
      sil_cnt_q <= sil_cnt_d;
    end
  end

  AST_FRM_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_act_q |-> (frm_cnt_q < FW'(FRAME_MAX_BITS))); // R2
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !brk_sync_seen) |=> (!frm_act_q && !rsp_act_q)); // R3
  AST_SIL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_act_q |-> (sil_cnt_q < SW'(RESP_MAX_BITS))); // R4
  AST_BRK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    brk_sync_seen |=> (frm_act_q && (frm_cnt_q == '0))); // R10

endmodule

// File: rtl/lin_ack_watch.sv
module lin_ack_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic slave_mode,
  input  logic id_rcvd,
  input  logic byte_rcvd,
  input  logic app_ack,
  input  logic app_stop,
  input  logic brk_sync_seen,
  input  logic frame_done,
  output logic ack_tmo
);

  logic pend_q, pend_d;
  logic answered;

  always_comb begin
    answered = app_ack || app_stop;
    ack_tmo  = pend_q && byte_rcvd && !answered && !brk_sync_seen && !frame_done;
  end

  always_comb begin
    pend_d = pend_q;
    if (brk_sync_seen || frame_done) begin
      pend_d = 1'b0;
    end else if (id_rcvd) begin
      pend_d = slave_mode && !answered;
    end else if (answered || byte_rcvd) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  AST_MASTER_NO_ACK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && id_rcvd) |=> !pend_q); // R5
  AST_ACK_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rcvd |=> !pend_q); // R5

endmodule

// File: rtl/lin_wake_watch.sv
module lin_wake_watch #(
  parameter int unsigned WAKE_MS = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slave_mode,
  input  logic wake_sent,
  input  logic ms_tick,
  input  logic brk_sync_seen,
  output logic wake_tmo
);

  localparam int unsigned WW = $clog2(WAKE_MS + 1);
  localparam logic [WW-1:0] WK_LAST = WW'(WAKE_MS - 1);

  logic          act_q, act_d;
  logic [WW-1:0] cnt_q, cnt_d;

  always_comb begin
    wake_tmo = act_q && ms_tick && (cnt_q == WK_LAST) && !brk_sync_seen &&
               !(slave_mode && wake_sent);
  end

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (brk_sync_seen) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (slave_mode && wake_sent) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (wake_tmo) begin
      act_d = 1'b0;
    end else if (act_q && ms_tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  AST_WAKE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q < WW'(WAKE_MS))); // R6
  AST_BRK_CANCELS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_sync_seen |=> !act_q); // R6

endmodule

// File: rtl/lin_err_reg.sv
module lin_err_reg
  import lin_tmo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  err_flags_t set_flags,
  input  logic       clr,
  output err_flags_t flags
);

  err_flags_t flags_q, flags_d;

  always_comb begin
    flags_d = clr ? err_flags_t'('0) : flags_q;
    flags_d = flags_d | set_flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags != '0) |=> ((flags_q & $past(set_flags)) == $past(set_flags))); // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (set_flags == '0)) |=> (flags_q == '0)); // R9

endmodule

// File: rtl/lin_tmo_mon.sv
module lin_tmo_mon
  import lin_tmo_pkg::*;
#(
  parameter int unsigned FRAME_MAX_BITS = 176,
  parameter int unsigned RESP_MAX_BITS  = 14,
  parameter int unsigned WAKE_MS        = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              expect_rx,
  input  logic              bit_tick,
  input  logic              ms_tick,
  input  logic              brk_sync_seen,
  input  logic              id_rcvd,
  input  logic              byte_rcvd,
  input  logic              frame_done,
  input  logic              wake_sent,
  input  logic              app_ack,
  input  logic              app_stop,
  input  logic              sync_err_in,
  input  logic              parity_err_in,
  input  logic              chk_err_in,
  input  logic              bit_slot,
  input  logic              bit_drv,
  input  logic              bit_mon,
  input  logic              clr_err,
  output logic              tmo_flag,
  output logic [STAT_W-1:0] err_stat
);

  // reset synchronizer: asserts asynchronously, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  logic       slave_mode;
  logic       frm_tmo, rsp_tmo, ack_tmo, wake_tmo;
  err_flags_t set_flags, flags;

  assign slave_mode = !is_master;

  lin_frame_timer #(
    .FRAME_MAX_BITS (FRAME_MAX_BITS),
    .RESP_MAX_BITS  (RESP_MAX_BITS)
  ) u_frame (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .bit_tick      (bit_tick),
    .brk_sync_seen (brk_sync_seen),
    .id_rcvd       (id_rcvd),
    .byte_rcvd     (byte_rcvd),
    .frame_done    (frame_done),
    .expect_rx     (expect_rx),
    .frm_tmo       (frm_tmo),
    .rsp_tmo       (rsp_tmo)
  );

  lin_ack_watch u_ack (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .slave_mode    (slave_mode),
    .id_rcvd       (id_rcvd),
    .byte_rcvd     (byte_rcvd),
    .app_ack       (app_ack),
    .app_stop      (app_stop),
    .brk_sync_seen (brk_sync_seen),
    .frame_done    (frame_done),
    .ack_tmo       (ack_tmo)
  );

  lin_wake_watch #(
    .WAKE_MS (WAKE_MS)
  ) u_wake (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .slave_mode    (slave_mode),
    .wake_sent     (wake_sent),
    .ms_tick       (ms_tick),
    .brk_sync_seen (brk_sync_seen),
    .wake_tmo      (wake_tmo)
  );

  always_comb begin
    set_flags.syn   = slave_mode && sync_err_in;
    set_flags.par   = slave_mode && parity_err_in;
    set_flags.tmo   = frm_tmo || rsp_tmo || ack_tmo || wake_tmo;
    set_flags.chk   = chk_err_in;
    set_flags.bit_e = bit_slot && (bit_drv != bit_mon);
  end

  lin_err_reg u_err (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .set_flags (set_flags),
    .clr       (clr_err),
    .flags     (flags)
  );

  assign err_stat = {{(STAT_W - FLAG_W){1'b0}}, flags};
  assign tmo_flag = flags.tmo;

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_stat[7:5] == 3'b000); // R1
  AST_MASTER_NO_SYNC_SET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (is_master && !err_stat[4]) |=> !err_stat[4]); // R7

endmodule

// File: tb/tb_lin_tmo_mon.sv
module tb_lin_tmo_mon;

  localparam int unsigned FRM = 40;
  localparam int unsigned RSP = 8;
  localparam int unsigned WMS = 150;

  logic clk;
  logic rst_n;
  logic is_master, expect_rx, bit_tick, ms_tick, brk_sync_seen, id_rcvd;
  logic byte_rcvd, frame_done, wake_sent, app_ack, app_stop;
  logic sync_err_in, parity_err_in, chk_err_in, bit_slot, bit_drv, bit_mon, clr_err;
  logic       tmo_flag;
  logic [7:0] err_stat;

  int n_chk;
  int n_fail;
  bit finished;

  lin_tmo_mon #(
    .FRAME_MAX_BITS (FRM),
    .RESP_MAX_BITS  (RSP),
    .WAKE_MS        (WMS)
  ) dut (
    .clk (clk), .rst_n (rst_n), .is_master (is_master), .expect_rx (expect_rx),
    .bit_tick (bit_tick), .ms_tick (ms_tick), .brk_sync_seen (brk_sync_seen),
    .id_rcvd (id_rcvd), .byte_rcvd (byte_rcvd), .frame_done (frame_done),
    .wake_sent (wake_sent), .app_ack (app_ack), .app_stop (app_stop),
    .sync_err_in (sync_err_in), .parity_err_in (parity_err_in),
    .chk_err_in (chk_err_in), .bit_slot (bit_slot), .bit_drv (bit_drv),
    .bit_mon (bit_mon), .clr_err (clr_err), .tmo_flag (tmo_flag),
    .err_stat (err_stat)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic zero_strobes();
    bit_tick = 0; ms_tick = 0; brk_sync_seen = 0; id_rcvd = 0; byte_rcvd = 0;
    frame_done = 0; wake_sent = 0; app_ack = 0; app_stop = 0; sync_err_in = 0;
    parity_err_in = 0; chk_err_in = 0; bit_slot = 0; bit_drv = 0; bit_mon = 0;
    clr_err = 0;
  endtask

  // one clock: strobes set before the call are seen at the next posedge
  task automatic tick();
    @(negedge clk);
    zero_strobes();
  endtask

  task automatic bits(input int n);
    for (int i = 0; i < n; i++) begin bit_tick = 1; tick(); end
  endtask

  task automatic mss(input int n);
    for (int i = 0; i < n; i++) begin ms_tick = 1; tick(); end
  endtask

  task automatic clear_all();
    clr_err = 1; frame_done = 1; tick();
  endtask

  // expected flag set vector, bits 4..0
  function automatic logic [4:0] exp_set(input logic mst, input logic syn, input logic par,
                                         input logic chk, input logic slot,
                                         input logic drv, input logic mon);
    exp_set = {(!mst && syn), (!mst && par), 1'b0, chk, (slot && (drv != mon))};
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [4:0] exp_f;
    n_chk = 0; n_fail = 0; finished = 0;
    void'($urandom(32'd20240611));
    is_master = 1; expect_rx = 0;
    zero_strobes();
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    check("R1 reset status", err_stat, 8'h00);
    check("R1 reset tmo", {7'b0, tmo_flag}, 8'h00);

    // R2 frame deadline, master, no response expected
    brk_sync_seen = 1; tick();
    bits(FRM - 1);
    check("R2 one tick before limit", {7'b0, tmo_flag}, 8'h00);
    bits(1);
    check("R2 at limit", {7'b0, tmo_flag}, 8'h01);
    check("R1 timeout at bit 2", err_stat, 8'h04);
    clr_err = 1; tick();
    check("R9 clear", err_stat, 8'h00);

    // R3 completed frame never times out
    brk_sync_seen = 1; tick();
    bits(30);
    frame_done = 1; tick();
    bits(30);
    check("R3 done stops deadline", err_stat, 8'h00);

    // R10 restart on new break
    brk_sync_seen = 1; tick();
    bits(30);
    brk_sync_seen = 1; tick();
    bits(FRM - 1);
    check("R10 restarted count below limit", {7'b0, tmo_flag}, 8'h00);
    bits(1);
    check("R10 restarted count at limit", {7'b0, tmo_flag}, 8'h01);
    clear_all();

    // R4 response silence
    expect_rx = 1;
    brk_sync_seen = 1; tick();
    id_rcvd = 1; tick();
    bits(RSP - 1);
    byte_rcvd = 1; tick();
    bits(RSP - 1);
    check("R4 byte restarts silence", {7'b0, tmo_flag}, 8'h00);
    bits(1);
    check("R4 silence limit", {7'b0, tmo_flag}, 8'h01);
    clear_all();
    expect_rx = 0;
    brk_sync_seen = 1; tick();
    id_rcvd = 1; tick();
    bits(RSP + 4);
    check("R4 not armed without expect", {7'b0, tmo_flag}, 8'h00);
    clear_all();

    // R5 application handshake, slave
    is_master = 0;
    brk_sync_seen = 1; tick();
    id_rcvd = 1; tick();
    bits(3);
    byte_rcvd = 1; tick();
    check("R5 late ack", {7'b0, tmo_flag}, 8'h01);
    clear_all();
    brk_sync_seen = 1; tick();
    id_rcvd = 1; tick();
    app_ack = 1; tick();
    byte_rcvd = 1; tick();
    check("R5 ack in time", {7'b0, tmo_flag}, 8'h00);
    clear_all();
    brk_sync_seen = 1; tick();
    id_rcvd = 1; tick();
    byte_rcvd = 1; app_stop = 1; tick();
    check("R5 stop same cycle", {7'b0, tmo_flag}, 8'h00);
    clear_all();
    is_master = 1;
    brk_sync_seen = 1; tick();
    id_rcvd = 1; tick();
    byte_rcvd = 1; tick();
    check("R5 master not armed", {7'b0, tmo_flag}, 8'h00);
    clear_all();

    // R6 wakeup watchdog
    is_master = 0;
    wake_sent = 1; tick();
    mss(WMS - 1);
    check("R6 before limit", {7'b0, tmo_flag}, 8'h00);
    mss(1);
    check("R6 at limit", {7'b0, tmo_flag}, 8'h01);
    clear_all();
    wake_sent = 1; tick();
    mss(100);
    brk_sync_seen = 1; tick();
    mss(100);
    check("R6 break cancels", {7'b0, tmo_flag}, 8'h00);
    clear_all();
    is_master = 1;
    wake_sent = 1; tick();
    mss(WMS + 10);
    check("R6 master not armed", {7'b0, tmo_flag}, 8'h00);
    clear_all();

    // directed R7/R8/R9 corners
    is_master = 1;
    sync_err_in = 1; parity_err_in = 1; tick();
    check("R7 master ignores sync/parity", err_stat, 8'h00);
    is_master = 0;
    sync_err_in = 1; clr_err = 1; tick();
    check("R9 set wins over clear", err_stat, 8'h10);
    bit_slot = 1; bit_drv = 1; bit_mon = 1; tick();
    check("R8 matching bit no error", err_stat, 8'h10);
    clr_err = 1; tick();

    // random R7/R8/R9 against bench model
    exp_f = '0;
    for (int i = 0; i < 400; i++) begin
      logic m, s, p, c, sl, d, mo, cl;
      m = $urandom % 2; s = ($urandom % 4) == 0; p = ($urandom % 4) == 0;
      c = ($urandom % 5) == 0; sl = $urandom % 2; d = $urandom % 2;
      mo = $urandom % 2; cl = ($urandom % 6) == 0;
      is_master = m; sync_err_in = s; parity_err_in = p; chk_err_in = c;
      bit_slot = sl; bit_drv = d; bit_mon = mo; clr_err = cl;
      exp_f = (cl ? 5'b0 : exp_f) | exp_set(m, s, p, c, sl, d, mo);
      tick();
      check("R7 R8 R9 random flags", err_stat, {3'b000, exp_f});
      check("R9 tmo mirrors bit 2", {7'b0, tmo_flag}, {7'b0, err_stat[2]});
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule